// File: doc/BRIEF.md
# Periodic Time Update Interrupt

This block raises an interrupt once per second or once per minute, driven by the carry strobes of a timekeeping chain. A select bit picks the source. Each selected carry sets a sticky update flag. When the update interrupt enable is set, the carry also starts an active-low interrupt pulse.

The low pulse ends by itself after a fixed number of strobes from a slow reference tick. With the default setting the tick is 4096 Hz and the count is 31, which gives about 7.57 ms. Software does not have to service the interrupt for the pin to be released. The pulse is kept separate from the flag. Clearing the flag leaves a running pulse alone. Clearing the enable releases the pin at once. A further carry that arrives during a pulse starts the window again from its full length.

All register writes are single-cycle strobes that each carry a value. Each written state bit is returned on an output of its own.

Top module: `upd_irq_gen`

## Requirements
- R1: After reset, the update flag, the enable and the select bit all read 0, and `irq_n` is 1 (released).
- R2: With select = 0, a `sec_carry` strobe sets the flag on the next cycle. A `min_carry` strobe has no effect on the flag.
- R3: With select = 1, a `min_carry` strobe sets the flag on the next cycle. A `sec_carry` strobe has no effect on the flag.
- R4: Writing 0 to the flag clears it, and writing 1 to it changes nothing. If a selected carry arrives in the same cycle as a clear, the flag ends up as 1.
- R5: A selected carry drives `irq_n` to 0 on the next cycle only if the enable is 1 after that cycle's write. With the enable at 0, the flag is still set but `irq_n` stays 1.
- R6: Once started, `irq_n` stays 0 for exactly LOW_TICKS `tick` strobes, counting those sampled after the starting cycle. It returns to 1 in the cycle after the last of those strobes.
- R7: Clearing the flag while `irq_n` is 0 does not release it.
- R8: Writing 0 to the enable releases `irq_n` on the next cycle, even in the middle of a window.
- R9: A selected carry during an active window restarts the count, so a full LOW_TICKS strobes are again needed.
- R10: Setting the enable while the flag is already 1 does not start a pulse. Only a carry does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_carry | input | 1 | One-cycle strobe on each second carry |
| min_carry | input | 1 | One-cycle strobe on each minute carry |
| tick | input | 1 | One-cycle strobe of the pulse-width reference (4096 Hz nominal) |
| wr_sel_en | input | 1 | Write strobe for the source select bit |
| wr_sel_val | input | 1 | Value for the select bit: 0 = seconds, 1 = minutes |
| wr_uie_en | input | 1 | Write strobe for the interrupt enable |
| wr_uie_val | input | 1 | Value for the enable |
| wr_uf_en | input | 1 | Write strobe for the update flag |
| wr_uf_val | input | 1 | Value for the flag; only 0 takes effect |
| sel_q | output | 1 | Current source select bit |
| uie_q | output | 1 | Current interrupt enable |
| uf_q | output | 1 | Sticky update flag |
| irq_n | output | 1 | Interrupt request: 0 = drive low, 1 = released |

## Verification
The bench measures the pulse width in tick strobes, both from a clean start and after a carry that restarts a running window. A counter that is off by one, or that does not reload on a restart, shows up as a pulse of the wrong length. The bench clears the flag in the middle of a pulse and checks that the pin stays low, so a design that ties the pin to the flag fails there. It also sets the enable while the flag is already 1, which catches a design whose pin follows flag AND enable. Finally it clears the flag in the same cycle as a carry, and it sends a carry from the source that is not selected, which catches a wrong priority between clear and set and a mix-up of the select bit.

// File: rtl/upd_irq_gen.sv
module upd_irq_gen #(
  parameter int LOW_TICKS = 31,
  localparam int CW = $clog2(LOW_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_carry,
  input  logic min_carry,
  input  logic tick,
  input  logic wr_sel_en,
  input  logic wr_sel_val,
  input  logic wr_uie_en,
  input  logic wr_uie_val,
  input  logic wr_uf_en,
  input  logic wr_uf_val,
  output logic sel_q,
  output logic uie_q,
  output logic uf_q,
  output logic irq_n
);

  logic          low_q;
  logic [CW-1:0] cnt_q;

  wire evt     = sel_q ? min_carry : sec_carry;
  wire uie_nx  = wr_uie_en ? wr_uie_val : uie_q;
  wire win_end = tick && (cnt_q == CW'(LOW_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      uie_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      if (wr_sel_en) sel_q <= wr_sel_val;
      uie_q <= uie_nx;
      if (evt)                         uf_q <= 1'b1;
      else if (wr_uf_en && !wr_uf_val) uf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (!uie_nx) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else if (evt) begin
      low_q <= 1'b1;
      cnt_q <= '0;
    end else if (low_q && tick) begin
      if (win_end) begin
        low_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign irq_n = ~low_q;

  AST_SEC_SETS_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && sec_carry) |=> uf_q); // R2
  AST_MIN_SETS_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && min_carry) |=> uf_q); // R3
  AST_UF_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_q && !evt) |=> !uf_q); // R4
  AST_LOW_NEEDS_UIE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> uie_q); // R5
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !tick && !(wr_uie_en && !wr_uie_val)) |=> !irq_n); // R7
  AST_UIE_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_uie_en && !wr_uie_val) |=> irq_n); // R8

endmodule

// File: tb/sim_upd_irq_gen.sv
`timescale 1ns/1ps
module sim_upd_irq_gen;
  localparam int LOW = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_carry = 0, min_carry = 0, tick = 0;
  logic wr_sel_en = 0, wr_sel_val = 0, wr_uie_en = 0, wr_uie_val = 0, wr_uf_en = 0, wr_uf_val = 0;
  logic sel_q, uie_q, uf_q, irq_n;

  int n_cmp = 0, n_bad = 0, cyc = 0, tick_cnt = 0, tdiv = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  upd_irq_gen #(.LOW_TICKS(LOW)) u0 (.*);

  // tick strobe once every 8 clocks
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 8;
    tick <= (tdiv == 0);
  end
  always @(posedge clk) if (tick) tick_cnt++;

  task automatic chk(string r, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_sel, m_uie, m_uf, m_low;
  int m_left;
  always @(posedge clk) begin
    bit nx, ev;
    if (!rst_n) begin
      m_sel = 0; m_uie = 0; m_uf = 0; m_low = 0; m_left = 0;
    end else begin
      nx = wr_uie_en ? wr_uie_val : m_uie;
      ev = m_sel ? min_carry : sec_carry;
      if (!nx) m_low = 0;
      else if (ev) begin m_low = 1; m_left = LOW; end
      else if (m_low && tick) begin m_left--; if (m_left == 0) m_low = 0; end
      if (ev) m_uf = 1;
      else if (wr_uf_en && !wr_uf_val) m_uf = 0;
      if (wr_sel_en) m_sel = wr_sel_val;
      m_uie = nx;
    end
    #1;
    if (!done) begin
      chk("R3 model sel", sel_q, m_sel);
      chk("R5 model uie", uie_q, m_uie);
      chk("R4 model uf", uf_q, m_uf);
      chk("R6 model irq", irq_n, !m_low);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask
  task automatic wr(ref logic en, ref logic v, input logic val);
    @(negedge clk) begin en = 1; v = val; end
    @(negedge clk) en = 0;
  endtask
  task automatic measure(string r, int exp);
    int st;
    st = tick_cnt;
    while (irq_n == 0) @(negedge clk);
    n_cmp++;
    if (tick_cnt - st != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d ticks", r, tick_cnt - st, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 uf", uf_q, 0); chk("R1 uie", uie_q, 0);
    chk("R1 sel", sel_q, 0); chk("R1 irq", irq_n, 1);
    rst_n = 1;
    pulse(sec_carry);
    chk("R2 sec sets uf", uf_q, 1); chk("R5 no irq when uie=0", irq_n, 1);
    wr(wr_uf_en, wr_uf_val, 0); chk("R4 clear", uf_q, 0);
    wr(wr_uf_en, wr_uf_val, 1); chk("R4 write1 ignored", uf_q, 0);
    pulse(min_carry); chk("R2 min ignored", uf_q, 0);
    wr(wr_sel_en, wr_sel_val, 1);
    pulse(sec_carry); chk("R3 sec ignored", uf_q, 0);
    pulse(min_carry); chk("R3 min sets uf", uf_q, 1);
    wr(wr_uie_en, wr_uie_val, 1); chk("R10 no pulse on enable", irq_n, 1);
    wr(wr_uf_en, wr_uf_val, 0);
    wr(wr_sel_en, wr_sel_val, 0);
    pulse(sec_carry); chk("R5 irq low", irq_n, 0);
    repeat (3) @(negedge clk);
    wr(wr_uf_en, wr_uf_val, 0); chk("R7 uf cleared", uf_q, 0);
    chk("R7 irq stays low", irq_n, 0);
    measure("R6 width", LOW - 0);
    chk("R6 released", irq_n, 1);
    pulse(sec_carry);
    repeat (20 * 8) @(negedge clk);
    chk("R9 still low", irq_n, 0);
    pulse(sec_carry);
    measure("R9 restart width", LOW);
    pulse(sec_carry);
    repeat (5) @(negedge clk);
    wr(wr_uie_en, wr_uie_val, 0); chk("R8 release", irq_n, 1);
    wr(wr_uf_en, wr_uf_val, 0);
    @(negedge clk) begin sec_carry = 1; wr_uf_en = 1; wr_uf_val = 0; end
    @(negedge clk) begin sec_carry = 0; wr_uf_en = 0; end
    chk("R4 event beats clear", uf_q, 1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule